// File: doc/BRIEF.md
# Bus-Serviced Watchdog Reset Supervisor

This block is the digital core of a supervisory watchdog. It holds a pair of complementary reset outputs (one active-high, one active-low) active while the supply is not good, keeps them active for a fixed power-up interval after the supply recovers, and then runs a watchdog counter. The host keeps the system out of reset by making the device acknowledge a valid serial-bus address. A real command or a dummy one both work. Every such acknowledge arrives as a single-cycle pulse on `ack_i` and restarts the watchdog count from zero.

If the watchdog count expires with no acknowledge, both reset outputs assert for exactly the power-up interval. They are then released, and the watchdog counts again from zero. A manual reset input also forces reset. That reset lasts for the longer of the power-up interval and the time the input is held. The supply-good flag and the manual reset are asynchronous, active-high inputs. Each passes through a two-flop synchronizer. The timeout and the power-up interval are parameters in clock cycles.

Top module: `wdog_supervisor`

## Requirements
- R1: While the synchronized supply-good flag is low, the block is in state HOLD (`state_o` = 2'b00) with `rst_o` = 1 and `rst_n_o` = 0. The synchronous `rst` input forces the same state. A fall of `supply_ok_i` driven between edges shows on the outputs after the third following rising clock edge.
- R2: After `supply_ok_i` rises and stays high, the reset outputs are released after exactly `PUR_CYCLES` + 2 rising edges, counted from the edge that follows the input change. The state then becomes COUNTING (2'b01).
- R3: In COUNTING, when no acknowledge arrives, the block enters TIMED_OUT (2'b10) exactly `WDT_CYCLES` edges after the edge that entered COUNTING or sampled the last acknowledge. On entry to TIMED_OUT, `rst_o` goes to 1 and `rst_n_o` goes to 0 together.
- R4: An `ack_i` pulse sampled in COUNTING restarts the count from zero. Acknowledge gaps of at most `WDT_CYCLES` edges never cause a timeout. An acknowledge on the final count edge wins over the timeout.
- R5: After a timeout, the reset outputs stay active for exactly `PUR_CYCLES` edges. The block then returns to COUNTING with the count at zero, so the next timeout without acknowledge comes `WDT_CYCLES` edges later.
- R6: `ack_i` has no effect in HOLD or TIMED_OUT. It neither shortens nor restarts the reset interval.
- R7: A manual reset held for L edges (L >= 1) asserts the outputs after the third edge. The outputs stay asserted for max(L, `PUR_CYCLES`) edges.
- R8: `rst_n_o` is always the complement of `rst_o`. `rst_o` is 1 exactly when the state is not COUNTING. The state code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forces HOLD |
| supply_ok_i | input | 1 | Supply above trip level (asynchronous, synchronized inside) |
| man_rst_i | input | 1 | Manual reset request, active high (asynchronous, synchronized inside) |
| ack_i | input | 1 | Single-cycle pulse when the device acknowledges a valid bus address |
| rst_o | output | 1 | Active-high system reset |
| rst_n_o | output | 1 | Active-low system reset |
| state_o | output | 2 | 00 HOLD, 01 COUNTING, 10 TIMED_OUT |

## Verification
A watchdog count that is off by one shows as a timeout one edge early or late. It becomes visible at the ports only when an acknowledge gap lands on `WDT_CYCLES` or `WDT_CYCLES` + 1, so the bench places gaps on exactly those boundaries. A reset-interval counter that restarts on an acknowledge, or that fails to reload on a manual-reset edge, shows as a reset pulse of the wrong length. That error appears within one interval, as soon as the reset is released. A synchronizer of the wrong depth moves every reset onset by whole cycles, and the onset is measured against the third edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Supervisor state; the code is visible on state_o.
    typedef enum logic [1:0] {
        ST_HOLD    = 2'b00,
        ST_COUNT   = 2'b01,
        ST_TIMEOUT = 2'b10
    } wd_state_e;

    // The asynchronous inputs, grouped for the synchronizer.
    typedef struct packed {
        logic man_rst;
        logic supply_ok;
    } wd_in_s;

    localparam int unsigned SYNC_STAGES = 2;

    // Counter width able to hold values 0 .. n-1 (minimum 1 bit).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Reset outputs are active in every state but COUNTING.
    function automatic logic in_reset(input wd_state_e s);
        return (s != ST_COUNT);
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch import wdog_pkg::*; #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = cnt_bits(LEN);
    localparam logic [W-1:0] START = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Down-counter: loads LEN-1, counts to zero, then rests there.
    always_ff @(posedge clk) begin
        if (rst || load_i)            cnt_q <= START;
        else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer import wdog_pkg::*; #(
    parameter int unsigned LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned W = cnt_bits(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Up-counter: clear wins over run.
    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (run_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor import wdog_pkg::*; #(
    parameter int unsigned WDT_CYCLES = 80_000_000,
    parameter int unsigned PUR_CYCLES = 10_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       man_rst_i,
    input  logic       ack_i,
    output logic       rst_o,
    output logic       rst_n_o,
    output logic [1:0] state_o
);
    wd_in_s    raw_in, syn_in;
    logic      sup_s, mrst_s, mrst_q, mrst_rise;
    logic      hold_req, fire;
    logic      wdt_last, stretch_done;
    logic      stretch_load, stretch_run;
    logic      tmr_clr, tmr_run;
    wd_state_e state_q, state_d;

    // Input synchronization
    assign raw_in.supply_ok = supply_ok_i;
    assign raw_in.man_rst   = man_rst_i;

    wdog_sync #(
        .WIDTH  ($bits(wd_in_s)),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign sup_s  = syn_in.supply_ok;
    assign mrst_s = syn_in.man_rst;

    always_ff @(posedge clk) begin
        if (rst) mrst_q <= 1'b0;
        else     mrst_q <= mrst_s;
    end

    assign mrst_rise = mrst_s & ~mrst_q;
    assign hold_req  = ~sup_s | mrst_s;

    // Timeout fires on the last count cycle unless an ack coincides.
    assign fire = (state_q == ST_COUNT) && wdt_last && !ack_i && !hold_req;

    // Reset-interval down-counter
    assign stretch_load = ~sup_s | mrst_rise | fire;
    assign stretch_run  = in_reset(state_q);

    wdog_stretch #(
        .LEN (PUR_CYCLES)
    ) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .load_i (stretch_load),
        .run_i  (stretch_run),
        .done_o (stretch_done)
    );

    // Watchdog up-counter
    assign tmr_run = (state_q == ST_COUNT);
    assign tmr_clr = !tmr_run || ack_i || wdt_last;

    wdog_timer #(
        .LEN (WDT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (tmr_clr),
        .run_i  (tmr_run),
        .last_o (wdt_last)
    );

    // State sequencing
    always_comb begin
        state_d = state_q;
        if (hold_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD, ST_TIMEOUT: if (stretch_done) state_d = ST_COUNT;
                ST_COUNT:            if (fire)         state_d = ST_TIMEOUT;
                default:                               state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    // Outputs
    assign rst_o   = (state_q != ST_COUNT);
    assign rst_n_o = (state_q == ST_COUNT);
    assign state_o = state_q;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk import wdog_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       ack_i,
    input logic       sup_s,
    input logic       mrst_s,
    input logic       wdt_last,
    input logic       stretch_done,
    input logic       rst_o,
    input logic       rst_n_o,
    input logic [1:0] state_o
);
    // R8
    outputs_complement_chk: assert property (@(posedge clk) disable iff (rst)
        rst_o != rst_n_o);

    // R8
    legal_state_chk: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);

    // R1
    supply_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sup_s |=> (state_o == ST_HOLD));

    // R7
    manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mrst_s |=> (state_o == ST_HOLD));

    // R4
    ack_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT && ack_i && sup_s && !mrst_s) |=> (state_o == ST_COUNT));

    // R3
    expiry_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_COUNT && wdt_last && !ack_i && sup_s && !mrst_s)
        |=> (state_o == ST_TIMEOUT && rst_o && !rst_n_o));

    // R6
    interval_not_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_TIMEOUT && !stretch_done && sup_s && !mrst_s)
        |=> (state_o == ST_TIMEOUT));

    // R5
    hold_not_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HOLD) |=> (state_o != ST_TIMEOUT));
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack_i        (ack_i),
    .sup_s        (sup_s),
    .mrst_s       (mrst_s),
    .wdt_last     (wdt_last),
    .stretch_done (stretch_done),
    .rst_o        (rst_o),
    .rst_n_o      (rst_n_o),
    .state_o      (state_o)
);

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;
    localparam int WDT = 40;
    localparam int PUR = 12;
    localparam logic [1:0] S_HOLD = 2'b00, S_COUNT = 2'b01, S_TOUT = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic man_rst = 1'b0;
    logic ack = 1'b0;
    logic rst_o, rst_n_o;
    logic [1:0] state;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdog_supervisor #(.WDT_CYCLES(WDT), .PUR_CYCLES(PUR)) u_wdog_supervisor (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok),
        .man_rst_i   (man_rst),
        .ack_i       (ack),
        .rst_o       (rst_o),
        .rst_n_o     (rst_n_o),
        .state_o     (state)
    );

    function automatic bit exp_timeout(input int gap);
        return gap > WDT;
    endfunction

    function automatic int exp_mrst_len(input int held);
        return (held > PUR) ? held : PUR;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_outs(input string req, input logic [1:0] exp_state);
        chk(state == exp_state, req, state, exp_state);
        chk(rst_o == (exp_state != S_COUNT) && rst_n_o == !rst_o, "R8",
            {rst_o, rst_n_o}, {exp_state != S_COUNT, exp_state == S_COUNT});
    endtask

    // Waits out a reset interval (ack toggling, R6); returns edges until COUNTING.
    task automatic wait_release(output int n, input bit toggle_ack);
        n = 0;
        while (rst_o && n < 10000) begin
            ack = toggle_ack ? ~ack : 1'b0;
            step();
            n++;
        end
        ack = 1'b0;
    endtask

    // Starts at t=0 in COUNTING; ack sampled at edge t=gap unless timeout first.
    task automatic run_gap(input int gap, output bit timed_out);
        timed_out = 1'b0;
        for (int k = 1; k < gap && !timed_out; k++) begin
            step();
            if (k < WDT) begin
                chk(state == S_COUNT, "R4", state, S_COUNT);
            end else if (k == WDT) begin
                chk(state == S_TOUT, "R3", state, S_TOUT);
                timed_out = 1'b1;
            end
        end
        if (!timed_out) begin
            ack = 1'b1;
            step();
            ack = 1'b0;
            chk(state == S_COUNT, "R4 ack restart", state, S_COUNT);
        end
        chk(timed_out == exp_timeout(gap), "R4 gap outcome", timed_out, exp_timeout(gap));
    endtask

    task automatic after_gap(input bit timed_out);
        int n;
        if (timed_out) begin
            chk_outs("R3", S_TOUT);
            wait_release(n, 1'b1);
            chk(n == PUR, "R5 timeout interval", n, PUR);
        end
    endtask

    task automatic mrst_pulse(input int held);
        int idx = 0, onset = -1, fin = -1;
        man_rst = 1'b1;
        while (idx < 1000 && fin < 0) begin
            ack = (idx % 3 == 1);
            step();
            idx++;
            if (idx == held) man_rst = 1'b0;
            if (onset < 0 && rst_o) onset = idx;
            if (onset >= 0 && fin < 0 && !rst_o) fin = idx;
        end
        ack = 1'b0;
        man_rst = 1'b0;
        chk(onset == 3, "R7 onset", onset, 3);
        chk(fin - onset == exp_mrst_len(held), "R7 length", fin - onset, exp_mrst_len(held));
        chk_outs("R7", S_COUNT);
    endtask

    task automatic supply_dip(input int low_len);
        int n;
        supply_ok = 1'b0;
        step(); step();
        chk(state == S_COUNT, "R1 latency", state, S_COUNT);
        step();
        chk_outs("R1 dip", S_HOLD);
        for (int i = 3; i < low_len; i++) step();
        supply_ok = 1'b1;
        wait_release(n, 1'b1);
        chk(n == PUR + 2, "R2 dip release", n, PUR + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        bit tout;
        int unsigned seed_v;
        seed_v = $urandom(32'd1789);

        // Reset state
        step(); step(); step();
        chk_outs("R1 sync reset", S_HOLD);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ack = i[0];
            step();
        end
        ack = 1'b0;
        chk_outs("R1 supply low", S_HOLD);

        // Power-up
        supply_ok = 1'b1;
        wait_release(n, 1'b1);
        chk(n == PUR + 2, "R2 power-up", n, PUR + 2);
        chk_outs("R2", S_COUNT);

        // Plain timeout
        n = 0;
        while (state == S_COUNT && n < 1000) begin
            step();
            n++;
        end
        chk(n == WDT, "R3 timeout period", n, WDT);
        chk_outs("R3", S_TOUT);
        wait_release(n, 1'b1);
        chk(n == PUR, "R6 ack in interval", n, PUR);

        // Directed gaps
        run_gap(WDT + 1, tout); after_gap(tout);   // R5 restart from zero
        run_gap(WDT, tout);     after_gap(tout);   // R4 ack on final cycle
        run_gap(1, tout);       after_gap(tout);
        run_gap(WDT, tout);     after_gap(tout);
        run_gap(WDT + 1, tout); after_gap(tout);   // R3

        // Random gaps
        for (int i = 0; i < 40; i++) begin
            int g;
            g = 1 + int'($urandom % (WDT + 3));
            run_gap(g, tout);
            after_gap(tout);
        end

        // Manual reset
        mrst_pulse(1);
        mrst_pulse(PUR);
        mrst_pulse(PUR + 7);
        mrst_pulse(2 + int'($urandom % (2 * PUR)));

        // Supply dip
        supply_dip(5);
        run_gap(WDT + 1, tout);
        after_gap(tout);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule